// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block adds a short integer dot product to each 32-bit lane of an accumulator vector. Every transfer brings an accumulator vector and two packed source vectors of the same width. A mode bit picks how the sources are read:

- **Byte form:** each lane gets four products of an unsigned source byte and a signed source byte.
- **Word form:** each lane gets two products of signed 16-bit halves.

A second bit picks how the lane sum is reduced to 32 bits. It either keeps the low 32 bits of the sum, or clamps the exact sum to the signed 32-bit range.

The ports always span `PORT_LANES` lanes. Only the first `LANES` lanes are computed; lane counts of four and eight are the intended settings. Result bits above the active lanes are driven to zero.

Transfers use a valid/ready handshake on both sides. There is one register stage, which can take a new operand set every cycle while the consumer keeps up. Mode and saturate select travel with the operands.

Top module: `pkd_dot_acc`

## Requirements
- R1: With `in_mode`=0 (byte form), lane j uses byte k of that lane (bits 32j+8k+7..32j+8k, k=0..3) from both sources. The byte of `in_a` is read as unsigned and the byte of `in_b` as signed. Each of the four products is a signed value that fits in 16 bits, and all four are added to accumulator lane j.
- R2: With `in_mode`=1 (word form), lane j uses half h of that lane (bits 32j+16h+15..32j+16h, h=0..1) from both sources, each read as signed. Both 32-bit signed products are added to accumulator lane j.
- R3: With `in_sat`=0, each lane result is the low 32 bits of the exact sum.
- R4: With `in_sat`=1, each lane result is the exact sum clamped to the range 0x80000000..0x7FFFFFFF (as signed 32-bit values). The clamp compares the full-precision sum, so overflow past either bound cannot be missed.
- R5: Bits of `out_data` at or above `LANES`*32 are always zero. The input bits at or above `LANES`*32 have no effect on any result.
- R6: An operand set is taken at a rising edge when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge. `in_ready` is low exactly when a result is held and `out_ready` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: Results appear in the order their operands were taken. While `in_valid` is low, the operand, mode and saturate inputs have no effect and no result is produced.
- R9: After reset, `out_valid` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_mode | input | 1 | 0 = byte form, 1 = word form |
| in_sat | input | 1 | 0 = wrap to 32 bits, 1 = signed saturation |
| in_acc | input | PORT_LANES*32 | Accumulator lanes |
| in_a | input | PORT_LANES*32 | First source (unsigned bytes or signed halves) |
| in_b | input | PORT_LANES*32 | Second source (signed bytes or signed halves) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | PORT_LANES*32 | Result lanes, zero above the active lanes |

## Verification
A result is due one cycle after its operand set is taken. It shows with `out_valid` after that same rising edge, and then holds for as long as the consumer withholds `out_ready`.

The driver holds each operand set until it sees `in_ready` high, and only then queues the expected vector. That vector comes from a signed 64-bit model of the lane sums. The monitor compares at the falling edge of each cycle in which `out_valid` and `out_ready` are both high. It also checks that the data is unchanged across stalled cycles and that `in_ready` is low during a stall.

Corner operands are included:
- byte 0xFF times byte 0x80 in every position with the most negative accumulator;
- halves 0x8000 times 0x8000 with the most positive accumulator.

Both are run in wrap and in saturate mode, among random traffic with junk driven on the upper lanes and between transfers.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int ACC_W           = 32;
  localparam int SUM_W           = ACC_W + 2;
  localparam int BYTE_W          = 8;
  localparam int HALF_W          = 16;
  localparam int BYTES_PER_LANE  = ACC_W / BYTE_W;
  localparam int HALVES_PER_LANE = ACC_W / HALF_W;

  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_WORD = 1'b1
  } dp_mode_e;

  // unsigned byte times signed byte; the product always fits in 16 signed bits
  function automatic logic signed [SUM_W-1:0] mul_ub_sb(input logic [BYTE_W-1:0] ua,
                                                        input logic [BYTE_W-1:0] sb);
    logic signed [BYTE_W:0]     za;
    logic signed [BYTE_W:0]     xb;
    logic signed [2*BYTE_W+1:0] p;
    za = {1'b0, ua};
    xb = {sb[BYTE_W-1], sb};
    p  = za * xb;
    return {{(SUM_W-2*BYTE_W){p[2*BYTE_W-1]}}, p[2*BYTE_W-1:0]};
  endfunction

  // signed half times signed half, kept at 32 signed bits
  function automatic logic signed [SUM_W-1:0] mul_sh_sh(input logic [HALF_W-1:0] ha,
                                                        input logic [HALF_W-1:0] hb);
    logic signed [HALF_W-1:0]   sa;
    logic signed [HALF_W-1:0]   sb;
    logic signed [2*HALF_W-1:0] p;
    sa = ha;
    sb = hb;
    p  = sa * sb;
    return {{(SUM_W-2*HALF_W){p[2*HALF_W-1]}}, p};
  endfunction
endpackage

// File: rtl/dpa_clamp.sv
module dpa_clamp
  import dpa_pkg::*;
(
  input  logic signed [SUM_W-1:0] sum,
  input  logic                    sat_en,
  output logic [ACC_W-1:0]        res
);
  localparam logic signed [SUM_W-1:0] HI_LIM = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO_LIM = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  logic over_hi;
  logic under_lo;

  always_comb begin
    over_hi  = sum > HI_LIM;
    under_lo = sum < LO_LIM;
    if (sat_en && over_hi)       res = HI_LIM[ACC_W-1:0];
    else if (sat_en && under_lo) res = LO_LIM[ACC_W-1:0];
    else                         res = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/dpa_lane.sv
module dpa_lane
  import dpa_pkg::*;
(
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] src_a,
  input  logic [ACC_W-1:0] src_b,
  input  dp_mode_e         mode,
  input  logic             sat_en,
  output logic [ACC_W-1:0] res
);
  logic signed [SUM_W-1:0] byte_p [BYTES_PER_LANE];
  logic signed [SUM_W-1:0] half_p [HALVES_PER_LANE];
  logic signed [SUM_W-1:0] byte_sum;
  logic signed [SUM_W-1:0] half_sum;
  logic signed [SUM_W-1:0] acc_x;
  logic signed [SUM_W-1:0] total;

  for (genvar k = 0; k < BYTES_PER_LANE; k++) begin : g_byte
    assign byte_p[k] = mul_ub_sb(src_a[k*BYTE_W +: BYTE_W], src_b[k*BYTE_W +: BYTE_W]);
  end

  for (genvar h = 0; h < HALVES_PER_LANE; h++) begin : g_half
    assign half_p[h] = mul_sh_sh(src_a[h*HALF_W +: HALF_W], src_b[h*HALF_W +: HALF_W]);
  end

  always_comb begin
    byte_sum = '0;
    for (int k = 0; k < BYTES_PER_LANE; k++) byte_sum = byte_sum + byte_p[k];
    half_sum = '0;
    for (int h = 0; h < HALVES_PER_LANE; h++) half_sum = half_sum + half_p[h];
    acc_x = {{(SUM_W-ACC_W){acc[ACC_W-1]}}, acc};
    total = acc_x + ((mode == MODE_WORD) ? half_sum : byte_sum);
  end

  dpa_clamp u_clamp (
    .sum    (total),
    .sat_en (sat_en),
    .res    (res)
  );
endmodule

// File: rtl/pkd_dot_acc.sv
module pkd_dot_acc
  import dpa_pkg::*;
#(
  parameter int PORT_LANES = 8,
  parameter int LANES      = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_mode,
  input  logic                        in_sat,
  input  logic [PORT_LANES*32-1:0]    in_acc,
  input  logic [PORT_LANES*32-1:0]    in_a,
  input  logic [PORT_LANES*32-1:0]    in_b,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [PORT_LANES*32-1:0]    out_data
);
  localparam int VEC_W = PORT_LANES * ACC_W;
  localparam int ACT_W = LANES * ACC_W;

  logic [VEC_W-1:0] next_data;
  dp_mode_e         mode_e;

  assign mode_e   = dp_mode_e'(in_mode);
  assign in_ready = !out_valid || out_ready;

  for (genvar j = 0; j < PORT_LANES; j++) begin : g_lane
    if (j < LANES) begin : g_act
      dpa_lane u_lane (
        .acc    (in_acc[j*ACC_W +: ACC_W]),
        .src_a  (in_a[j*ACC_W +: ACC_W]),
        .src_b  (in_b[j*ACC_W +: ACC_W]),
        .mode   (mode_e),
        .sat_en (in_sat),
        .res    (next_data[j*ACC_W +: ACC_W])
      );
    end else begin : g_off
      logic unused_in;
      assign unused_in = ^{in_acc[j*ACC_W +: ACC_W], in_a[j*ACC_W +: ACC_W], in_b[j*ACC_W +: ACC_W]};
      assign next_data[j*ACC_W +: ACC_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));

  // R6
  take_gives_result_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    ((!out_valid || out_ready) && !in_valid) |=> !out_valid);

  if (LANES < PORT_LANES) begin : g_hi_chk
    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      out_data[VEC_W-1:ACT_W] == '0);
  end
endmodule

// File: tb/tb_pkd_dot_acc.sv
`timescale 1ns/1ps
module tb_pkd_dot_acc;
  localparam int PL = 8;
  localparam int AL = 4;
  localparam int W  = PL * 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_mode = 1'b0;
  logic         in_sat = 1'b0;
  logic [W-1:0] in_acc = '0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int stall_pct = 30;

  typedef struct {
    logic [W-1:0] data;
    string        tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  pkd_dot_acc #(.PORT_LANES(PL), .LANES(AL)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_sat(in_sat), .in_acc(in_acc), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [W-1:0] model(input bit mode, input bit sat,
                                         input logic [W-1:0] s, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    for (int j = 0; j < AL; j++) begin
      longint sum = longint'($signed(s[j*32 +: 32]));
      if (!mode) begin
        for (int k = 0; k < 4; k++)
          sum += longint'(a[j*32+k*8 +: 8]) * longint'($signed(b[j*32+k*8 +: 8]));
      end else begin
        for (int h = 0; h < 2; h++)
          sum += longint'($signed(a[j*32+h*16 +: 16])) * longint'($signed(b[j*32+h*16 +: 16]));
      end
      if (sat && sum > 64'sd2147483647)  sum = 64'sd2147483647;
      if (sat && sum < -64'sd2147483648) sum = -64'sd2147483648;
      r[j*32 +: 32] = sum[31:0];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input bit mode, input bit sat, input logic [W-1:0] s,
                      input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_sat = sat;
    in_acc = s; in_a = a; in_b = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e.data = model(mode, sat, s, a, b);
    e.tag  = {mode ? "R2" : "R1", sat ? "/R4" : "/R3"};
    sb_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    #1;
    // R6: result shows after the taking edge
    check(out_valid === 1'b1, "R6 valid after take", W'(out_valid), W'(1));
    in_valid = 1'b0;
  endtask

  task automatic idle_junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_mode = 1'($urandom); in_sat = 1'($urandom);
      for (int w = 0; w < PL; w++) begin
        in_acc[w*32 +: 32] = $urandom; in_a[w*32 +: 32] = $urandom; in_b[w*32 +: 32] = $urandom;
      end
    end
  endtask

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] v;
    for (int w = 0; w < PL; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [W-1:0] fill32(input logic [31:0] x);
    logic [W-1:0] v;
    for (int w = 0; w < PL; w++) v[w*32 +: 32] = x;
    return v;
  endfunction

  // monitor / scoreboard
  initial begin : monitor
    logic [W-1:0] prev = '0;
    bit           prev_stall = 0;
    exp_t         e;
    forever begin
      @(negedge clk);
      if (!rst) out_ready = (($urandom % 100) >= stall_pct);
      #0.2;
      if (rst) begin
        prev_stall = 0;
      end else if (out_valid && out_ready) begin
        prev_stall = 0;
        // R8: every result matches a taken operand set, in order
        check(sb_q.size() > 0, "R8 unexpected result", out_data, '0);
        if (sb_q.size() > 0) begin
          e = sb_q.pop_front();
          check(out_data === e.data, e.tag, out_data, e.data);
          // R5: upper lanes zero
          check(out_data[W-1:AL*32] === '0, "R5 upper lanes", out_data, e.data);
        end
      end else if (out_valid && !out_ready) begin
        // R6: no intake while a result is held
        check(in_ready === 1'b0, "R6 ready low in stall", W'(in_ready), W'(0));
        // R7: data held through stall
        if (prev_stall) check(out_data === prev, "R7 hold", out_data, prev);
        prev = out_data;
        prev_stall = 1;
      end else begin
        prev_stall = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    logic [W-1:0] ff_a, x80_b, min_s, max_s, h8000;
    repeat (3) @(negedge clk);
    #0.5;
    // R9
    check(out_valid === 1'b0, "R9 valid in reset", W'(out_valid), W'(0));
    check(out_data === '0, "R9 data in reset", out_data, '0);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    check(out_valid === 1'b0 && out_data === '0, "R9 after reset", out_data, '0);

    ff_a  = fill32(32'hFFFF_FFFF);
    x80_b = fill32(32'h8080_8080);
    min_s = fill32(32'h8000_0000);
    max_s = fill32(32'h7FFF_FFFF);
    h8000 = fill32(32'h8000_8000);

    stall_pct = 0;
    // R1 simple: 1*1 +2*2+3*3+4*4 = 30 plus acc
    send(1'b0, 1'b0, fill32(32'd5), fill32(32'h0403_0201), fill32(32'h0403_0201));
    // R1 corner: 0xFF*0x80 everywhere, most negative acc: wrap (R3) and clamp (R4)
    send(1'b0, 1'b0, min_s, ff_a, x80_b);
    send(1'b0, 1'b1, min_s, ff_a, x80_b);
    // R2 corner: 0x8000*0x8000 twice on max acc: wrap (R3) and clamp (R4)
    send(1'b1, 1'b0, max_s, h8000, h8000);
    send(1'b1, 1'b1, max_s, h8000, h8000);
    // R4 no clamp when in range
    send(1'b1, 1'b1, fill32(32'd100), fill32(32'h0002_FFFF), fill32(32'h0003_0007));
    // R8 junk while idle
    idle_junk(4);
    send(1'b0, 1'b1, max_s, ff_a, fill32(32'h7F7F_7F7F));

    // back-to-back random traffic with stalls
    stall_pct = 35;
    for (int i = 0; i < 120; i++) begin
      send(1'($urandom), 1'($urandom), rnd_vec(), rnd_vec(), rnd_vec());
      if (i % 7 == 3) idle_junk(2);
    end

    stall_pct = 0;
    while (sb_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #0.5;
    check(out_valid === 1'b0, "R8 quiet at end", W'(out_valid), W'(0));
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule